// File: doc/BRIEF.md
# Banked SRAM Interface Controller

This block sits between an internal requester and an external asynchronous static RAM. It turns each internal read or write request into one complete bus cycle. Every cycle has an address setup clock, a strobe phase, and a release clock. The external bus carries a 16-bit address and 16-bit data. It has separate active-low read and write strobes and four active-low chip selects.

The 64 pages of 1024 words in the address space are split into four banks by four 8-bit boundary values. Each access asserts exactly one chip select, chosen from the page number of its address. A 3-bit wait-state setting stretches the strobe phase of every access by 0 to 7 clocks. The requester holds its request until it sees a single-clock acknowledge. Read data is presented together with that acknowledge.

The bank boundaries and the wait-state count are sampled when a request is accepted. Changing them during a cycle has no effect on that cycle.

Top module: `sram_bank_ctrl`

## Requirements
- R1: While reset is held and after its release, `ram_cs_n` is 4'b1111, `ram_rd_n` and `ram_wr_n` are 1, and `req_ack` and `ram_data_oe` are 0.
- R2: The page number is `req_addr[15:10]`. Boundary k is `cfg_bound[8k+7:8k]`. The bank is the lowest k (0 first) whose boundary is greater than the page. If no boundary is greater, bank 3 is used. Bank k drives `ram_cs_n[k]` low.
- R3: At most one chip select is low at any time. All chip selects are high in every clock outside an access.
- R4: A request is accepted at a rising edge where the block is idle and `req_valid` is 1. The next clock is setup: chip select low, strobes high. The strobe is then low for 1+W clocks, where W is `cfg_wait`. A release clock follows, with strobes high, the chip select still low and `req_ack` high. The block is then idle again.
- R5: A read (`req_write`=0) uses only `ram_rd_n`. A write uses only `ram_wr_n`. The two strobes are never low together.
- R6: `ram_addr` carries the request address from setup through release. For a write, `ram_data_oe` is 1 and `ram_wdata` carries the request data over the same span. For a read, `ram_data_oe` is 0.
- R7: A read captures `ram_rdata` at the rising edge that ends the strobe phase. The captured value appears on `rsp_rdata` from the acknowledge clock on, and stays there until the next read completes. Writes leave it unchanged.
- R8: `req_ack` is high for exactly one clock per access. A `req_valid` still high during the release clock does not start a new access; the clock after release is always idle.
- R9: `cfg_wait` and `cfg_bound` are sampled at acceptance. A change of `cfg_wait` during an access does not alter that access's strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address of the request |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Last captured read data |
| cfg_bound | input | 32 | Four 8-bit bank boundaries (in pages) |
| cfg_wait | input | 3 | Extra strobe clocks per access |
| ram_addr | output | 16 | Memory address |
| ram_wdata | output | 16 | Memory write data |
| ram_data_oe | output | 1 | Drive enable for the memory data bus |
| ram_rdata | input | 16 | Memory read data |
| ram_cs_n | output | 4 | Active-low bank chip selects |
| ram_rd_n | output | 1 | Active-low read strobe |
| ram_wr_n | output | 1 | Active-low write strobe |

## Verification
A wrong cycle state or wait count shows up directly at the ports. It appears as a strobe one clock too long or too short, or as an acknowledge in the wrong clock, within the 3 to 10 clocks of the access itself. A bad bank decode shows on the chip selects in the setup clock of the access. A misplaced capture edge returns read data tagged with the wrong strobe-clock index. The bench therefore sweeps every page under several boundary sets and every wait count, checking each clock of each access.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RELEASE = 2'd3
    } cyc_state_e;
endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
    parameter int PAGE_W    = 6,
    parameter int NUM_BANKS = 4,
    parameter int BOUND_W   = 8
) (
    input  logic [PAGE_W-1:0]            page,
    input  logic [NUM_BANKS*BOUND_W-1:0] bounds,
    output logic [NUM_BANKS-1:0]         sel
);
    localparam int CMP_W = (PAGE_W > BOUND_W) ? PAGE_W : BOUND_W;

    logic [NUM_BANKS-1:0] above;
    logic [CMP_W-1:0]     page_ext;

    assign page_ext = CMP_W'(page);

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_cmp
        assign above[gi] = CMP_W'(bounds[gi*BOUND_W +: BOUND_W]) > page_ext;
    end

    // lowest bank whose boundary lies above the page wins; last bank catches the rest
    always_comb begin
        logic found;
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (above[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
        if (!found) begin
            sel[NUM_BANKS-1] = 1'b1;
        end
    end
endmodule

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4: the count never moves without being told to
    assert_timer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q));
endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
    import sram_bank_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter int BOUND_W   = 8,
    parameter int PAGE_LSB  = 10,
    parameter int WAIT_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         req_ack,
    output logic [DATA_W-1:0]            rsp_rdata,
    input  logic [NUM_BANKS*BOUND_W-1:0] cfg_bound,
    input  logic [WAIT_W-1:0]            cfg_wait,
    output logic [ADDR_W-1:0]            ram_addr,
    output logic [DATA_W-1:0]            ram_wdata,
    output logic                         ram_data_oe,
    input  logic [DATA_W-1:0]            ram_rdata,
    output logic [NUM_BANKS-1:0]         ram_cs_n,
    output logic                         ram_rd_n,
    output logic                         ram_wr_n
);
    localparam int PAGE_W = ADDR_W - PAGE_LSB;
    localparam int CMP_W  = (PAGE_W > BOUND_W) ? PAGE_W : BOUND_W;

    typedef struct packed {
        cyc_state_e           st;
        logic [NUM_BANKS-1:0] cs_n;
        logic                 rd_n;
        logic                 wr_n;
        logic                 is_wr;
        logic                 ack;
        logic                 oe;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
        logic [DATA_W-1:0]    rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_BANKS-1:0] bank_sel;
    logic                 tmr_load;
    logic                 tmr_dec;
    logic                 tmr_expired;

    sram_bank_decode #(
        .PAGE_W   (PAGE_W),
        .NUM_BANKS(NUM_BANKS),
        .BOUND_W  (BOUND_W)
    ) u_decode (
        .page  (req_addr[ADDR_W-1:PAGE_LSB]),
        .bounds(cfg_bound),
        .sel   (bank_sel)
    );

    sram_wait_timer #(
        .WAIT_W(WAIT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(cfg_wait),
        .dec     (tmr_dec),
        .expired (tmr_expired)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        tmr_load  = 1'b0;
        tmr_dec   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.cs_n = '1;
                ctl_d.rd_n = 1'b1;
                ctl_d.wr_n = 1'b1;
                ctl_d.oe   = 1'b0;
                if (req_valid) begin
                    ctl_d.st    = ST_SETUP;
                    ctl_d.cs_n  = ~bank_sel;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.is_wr = req_write;
                    ctl_d.oe    = req_write;
                    tmr_load    = 1'b1;
                end
            end
            ST_SETUP: begin
                ctl_d.st   = ST_STROBE;
                ctl_d.rd_n = ctl_q.is_wr;
                ctl_d.wr_n = !ctl_q.is_wr;
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    ctl_d.st   = ST_RELEASE;
                    ctl_d.rd_n = 1'b1;
                    ctl_d.wr_n = 1'b1;
                    ctl_d.ack  = 1'b1;
                    if (!ctl_q.is_wr) begin
                        ctl_d.rdata = ram_rdata;
                    end
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_RELEASE: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.cs_n = '1;
                ctl_d.oe   = 1'b0;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.cs_n  <= '1;
            ctl_q.rd_n  <= 1'b1;
            ctl_q.wr_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ack     = ctl_q.ack;
    assign rsp_rdata   = ctl_q.rdata;
    assign ram_addr    = ctl_q.addr;
    assign ram_wdata   = ctl_q.wdata;
    assign ram_data_oe = ctl_q.oe;
    assign ram_cs_n    = ctl_q.cs_n;
    assign ram_rd_n    = ctl_q.rd_n;
    assign ram_wr_n    = ctl_q.wr_n;

    // R3: never two banks selected
    assert_one_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ram_cs_n));

    // R3: a strobe always has exactly one bank behind it
    assert_strobe_has_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_rd_n || !ram_wr_n) |-> ($countones(~ram_cs_n) == 1));

    // R5: read and write strobes are exclusive
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_rd_n && !ram_wr_n));

    // R8: acknowledge is a single clock and is followed by idle
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (!req_ack && (&ram_cs_n)));

    // R4: acknowledge arrives in the release clock
    assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (ram_rd_n && ram_wr_n && !(&ram_cs_n)));

    // R6: address and write data hold while the bank stays selected
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&ram_cs_n) && !$past(&ram_cs_n)) |-> ($stable(ram_addr) && $stable(ram_wdata)));

    // R2: a chosen non-final bank has its boundary above the page
    for (genvar gi = 0; gi < NUM_BANKS - 1; gi++) begin : g_bank_chk
        assert_bank_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(&ram_cs_n) && !ram_cs_n[gi]) |->
            (CMP_W'($past(cfg_bound[gi*BOUND_W +: BOUND_W])) > CMP_W'(ram_addr[ADDR_W-1:PAGE_LSB])));
    end
endmodule

// File: tb/sram_bank_ctrl_bench.sv
module sram_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic [31:0] cfg_bound = '0;
    logic [2:0]  cfg_wait = '0;
    logic [15:0] ram_addr;
    logic [15:0] ram_wdata;
    logic        ram_data_oe;
    logic [15:0] ram_rdata;
    logic [3:0]  ram_cs_n;
    logic        ram_rd_n;
    logic        ram_wr_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [3:0]  rcnt = '0;
    logic [15:0] last_rd = '0;

    always #5 clk = ~clk;

    sram_bank_ctrl u_sram_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .cfg_bound(cfg_bound), .cfg_wait(cfg_wait),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_data_oe(ram_data_oe),
        .ram_rdata(ram_rdata), .ram_cs_n(ram_cs_n), .ram_rd_n(ram_rd_n),
        .ram_wr_n(ram_wr_n)
    );

    // memory model: data depends on address and on how many strobe clocks have passed
    always @(posedge clk) begin
        if (!ram_rd_n) rcnt <= rcnt + 1'b1;
        else           rcnt <= '0;
    end
    assign ram_rdata = ram_rd_n ? 16'h0000 : (ram_addr ^ {rcnt, 12'h000} ^ 16'h5a5a);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cs(input logic [15:0] a, input logic [31:0] b);
        int sel = 3;
        for (int k = 3; k >= 0; k--) begin
            if (b[8*k +: 8] > {2'b00, a[15:10]}) sel = k;
        end
        return ~(4'b0001 << sel);
    endfunction

    // one access, starting and ending at a falling edge
    task automatic access(input logic wr, input logic [15:0] a, input logic [2:0] w,
                          input bit disturb);
        logic [15:0] d = a ^ 16'hc3c3;
        logic [3:0]  cs = exp_cs(a, cfg_bound);
        int          last = 3 + int'(w);
        cfg_wait  = w;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        for (int c = 1; c <= last; c++) begin
            bit stb;
            @(negedge clk);
            if (c == 1 && disturb) cfg_wait = ~w;   // R9 disturbance
            stb = (c >= 2) && (c <= 2 + int'(w));
            chk({28'h0, ram_cs_n}, {28'h0, cs}, "R2 chip select");
            chk({31'h0, ram_rd_n}, {31'h0, !(stb && !wr)}, disturb ? "R9 read strobe" : "R4 read strobe");
            chk({31'h0, ram_wr_n}, {31'h0, !(stb && wr)}, disturb ? "R9 write strobe" : "R5 write strobe");
            chk({31'h0, req_ack}, {31'h0, c == last}, "R8 ack timing");
            chk({16'h0, ram_addr}, {16'h0, a}, "R6 address");
            chk({31'h0, ram_data_oe}, {31'h0, wr}, "R6 drive enable");
            if (wr) chk({16'h0, ram_wdata}, {16'h0, d}, "R6 write data");
        end
        if (!wr) last_rd = a ^ {1'b0, w, 12'h000} ^ 16'h5a5a;
        chk({16'h0, rsp_rdata}, {16'h0, last_rd}, "R7 read data");
        req_valid = 1'b0;   // still high during release: R8 says it is ignored
        @(negedge clk);
        chk({28'h0, ram_cs_n}, 32'h0000000f, "R3 idle chip selects");
        chk({30'h0, ram_rd_n, ram_wr_n}, 32'h3, "R8 no restart after release");
        chk({31'h0, req_ack}, 32'h0, "R8 ack single clock");
        chk({16'h0, rsp_rdata}, {16'h0, last_rd}, "R7 read data held");
    endtask

    task automatic sweep_pages(input logic [31:0] b);
        cfg_bound = b;
        for (int p = 0; p < 64; p++) begin
            logic [15:0] a = {p[5:0], 10'(p * 37 + 5)};
            access(p[0], a, 3'(p % 8), 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({28'h0, ram_cs_n}, 32'h0000000f, "R1 cs in reset");
        chk({29'h0, ram_rd_n, ram_wr_n, req_ack}, 32'h6, "R1 strobes/ack in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({28'h0, ram_cs_n}, 32'h0000000f, "R1 cs after reset");
        chk({30'h0, ram_data_oe, req_ack}, 32'h0, "R1 oe/ack after reset");

        // R2 bank decode under several boundary sets (byte k = bank k)
        sweep_pages({8'd60, 8'd40, 8'd20, 8'd8});
        sweep_pages(32'h0000_0000);
        sweep_pages({8'd5, 8'd255, 8'd10, 8'd30});
        sweep_pages({8'd0, 8'd0, 8'd64, 8'd63});

        // R4 every wait count for reads and writes
        cfg_bound = {8'd48, 8'd32, 8'd16, 8'd4};
        for (int w = 0; w < 8; w++) begin
            access(1'b0, 16'(16'h1234 + w * 16'h0800), 3'(w), 1'b0);
            access(1'b1, 16'(16'hfedc - w * 16'h0400), 3'(w), 1'b0);
        end

        // R9 changing the wait setting mid-access has no effect
        for (int w = 0; w < 8; w++) begin
            access(w[0], 16'(16'h0a0a + w * 16'h1111), 3'(w), 1'b1);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule